// File: doc/BRIEF.md
# Functional Unit Issue Scheduler

This block sits between the wakeup logic of an out-of-order core and its pipelined execution units. Instructions that have all their operands are pushed into a ready queue kept per functional-unit class, each entry naming an in-flight slot and the tag that slot had when the entry was written. Every cycle, each class launches the instruction at the head of its queue into one of its units, provided a unit is free. Each class has a fixed initiation interval and a fixed latency. A launch therefore schedules two future events: the unit returning to the free pool, and the result completing.

Flushes are not signalled to this block directly. A vector of live tags, one per slot, is an input. Any queued or in-flight entry whose stored tag no longer matches its slot's live tag is stale. A stale queue head is dropped and wakes one stalled waiter of that class. A stale completion is dropped silently, although the unit it occupied is still returned on time. One class is the address-generation class for memory operations. Its completions leave on a separate address-done port that feeds disambiguation, not on the done port.

Top module: `fus_issue_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all outputs are 0. Every class starts with its configured unit count free and an empty queue.
- R2: Each class has a first-in first-out ready queue of QDEPTH entries (default 4), and heads issue in push order. A push offered while that class's queue already holds QDEPTH entries is ignored, and that instruction never issues or completes.
- R3: A class issues at most one instruction per cycle. `issue_o[c]` is high in a cycle when the queue head exists, is live, and the class has a free unit. An entry pushed in cycle n can issue at the earliest in cycle n+1.
- R4: Each issue takes one unit of its class. `unit_free_o[c]` pulses exactly REPEAT[c] cycles after the issue and returns the unit, which can be issued again in that same cycle. At no time are more than UNITS[c] units busy.
- R5: Exactly LATENCY[c] cycles after an issue, `done_vld_o[c]` pulses with the slot on `done_slot_o[c*SLOT_W +: SLOT_W]`, provided the slot's live tag still equals the tag it was pushed with.
- R6: A completion whose slot's live tag has changed produces no pulse at all. The unit release of that instruction is unaffected.
- R7: Completions of class ADDR_CLASS (default 2) appear only on `addr_done_vld_o`/`addr_done_slot_o`, and `done_vld_o[ADDR_CLASS]` stays 0.
- R8: When the queue head's stored tag differs from `live_tag_i[slot*TAG_W +: TAG_W]`, the head is removed without issuing or consuming a unit, and `waiter_rel_o[c]` pulses in that cycle.
- R9: Classes run independently. All completions that mature in one cycle are reported in that cycle. Per-class settings sit in 4-bit fields, with class c at bits [4c+3:4c] of REPEAT_VEC, LAT_VEC and UNITS_VEC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_vld_i | input | NUM_CLASS | Per-class ready push |
| push_slot_i | input | NUM_CLASS*SLOT_W | Slot of each push, class c at [c*SLOT_W +: SLOT_W] |
| push_tag_i | input | NUM_CLASS*TAG_W | Tag of each push, class c at [c*TAG_W +: TAG_W] |
| live_tag_i | input | 2**SLOT_W*TAG_W | Current tag of every slot |
| issue_o | output | NUM_CLASS | Instruction launched this cycle |
| waiter_rel_o | output | NUM_CLASS | Stale head dropped; release one stalled waiter |
| unit_free_o | output | NUM_CLASS | Unit returned to the free pool |
| done_vld_o | output | NUM_CLASS | Result completion to the done stage |
| done_slot_o | output | NUM_CLASS*SLOT_W | Slot of each completion |
| addr_done_vld_o | output | 1 | Address generation complete |
| addr_done_slot_o | output | SLOT_W | Slot whose address is ready |

## Verification
Results fall due at known times. An issue comes at the earliest one cycle after the push. A waiter release shows in the same cycle the stale head is seen. A unit release comes REPEAT cycles after its issue, and a completion comes LATENCY cycles after it. The bench keeps a model in which every issue posts its two events into per-class calendars at the current cycle plus the interval. It drives inputs on the falling edge and compares every output of that cycle 2 ns later, before the next rising edge. Random pushes and flushes are mixed with directed runs: a full queue receiving one push too many, back-to-back issues into a single unit, a head that is stale on arrival, a flush while an instruction is in flight, and an address-class completion.

// File: rtl/fus_pkg.sv
package fus_pkg;
   localparam int CFG_W = 4;

   // Extract the 4-bit setting of class c from a packed per-class vector.
   function automatic int cfg_field(logic [63:0] vec, int c);
      logic [CFG_W-1:0] f;
      f = vec[c*CFG_W +: CFG_W];
      return {28'd0, f};
   endfunction
endpackage

// File: rtl/fus_ready_fifo.sv
module fus_ready_fifo #(
   parameter int W     = 7,
   parameter int DEPTH = 4
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         push_i,
   input  logic [W-1:0] din_i,
   input  logic         pop_i,
   output logic [W-1:0] dout_o,
   output logic         empty_o
);
   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("fus_ready_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0] mem_q [DEPTH];
   logic [AW:0]  wp_q, rp_q;
   logic         full, do_push, do_pop;

   assign empty_o = (wp_q == rp_q);
   assign full    = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
   assign do_push = push_i && !full;
   assign do_pop  = pop_i && !empty_o;
   assign dout_o  = mem_q[rp_q[AW-1:0]];

   always_ff @(posedge clk_i) begin
      if (do_push) mem_q[wp_q[AW-1:0]] <= din_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wp_q <= '0;
         rp_q <= '0;
      end else begin
         if (do_push) wp_q <= wp_q + 1'b1;
         if (do_pop)  rp_q <= rp_q + 1'b1;
      end
   end
endmodule

// File: rtl/fus_delay_line.sv
module fus_delay_line #(
   parameter int W     = 1,
   parameter int DEPTH = 1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("fus_delay_line: DEPTH must be at least 1");
   end

   if (DEPTH == 1) begin : g_single
      logic [W-1:0] stg_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) stg_q <= '0;
         else         stg_q <= d_i;
      end
      assign q_o = stg_q;
   end else begin : g_chain
      logic [W-1:0] stg_q [DEPTH];
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) stg_q[i] <= '0;
         end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < DEPTH; i++) stg_q[i] <= stg_q[i-1];
         end
      end
      assign q_o = stg_q[DEPTH-1];
   end
endmodule

// File: rtl/fus_class_lane.sv
module fus_class_lane #(
   parameter int SLOT_W = 3,
   parameter int TAG_W  = 4,
   parameter int QDEPTH = 4,
   parameter int UNITS  = 1,
   parameter int REP    = 1,
   parameter int LAT    = 1
) (
   input  logic                            clk_i,
   input  logic                            rst_ni,
   input  logic                            push_vld_i,
   input  logic [SLOT_W+TAG_W-1:0]         push_ent_i,
   input  logic [(1<<SLOT_W)*TAG_W-1:0]    live_tag_i,
   output logic                            issue_o,
   output logic                            waiter_rel_o,
   output logic                            unit_free_o,
   output logic                            cmp_vld_o,
   output logic [SLOT_W-1:0]               cmp_slot_o
);
   localparam int EW = SLOT_W + TAG_W;
   localparam int CW = $clog2(UNITS + 1);

   logic [EW-1:0]     head;
   logic              head_empty, head_stale, can_issue, rel_now;
   logic [SLOT_W-1:0] head_slot, mat_slot;
   logic [TAG_W-1:0]  head_tag, mat_tag;
   logic [EW:0]       cmp_q;
   logic [CW-1:0]     free_q, free_d;

   fus_ready_fifo #(.W(EW), .DEPTH(QDEPTH)) u_rdyq (
      .clk_i, .rst_ni,
      .push_i (push_vld_i),
      .din_i  (push_ent_i),
      .pop_i  (can_issue || head_stale),
      .dout_o (head),
      .empty_o(head_empty)
   );

   assign head_slot  = head[EW-1:TAG_W];
   assign head_tag   = head[TAG_W-1:0];
   assign head_stale = !head_empty && (live_tag_i[head_slot*TAG_W +: TAG_W] != head_tag);
   assign can_issue  = !head_empty && !head_stale && ((free_q != '0) || rel_now);

   // Unit release event, REP cycles after issue
   fus_delay_line #(.W(1), .DEPTH(REP)) u_rel (
      .clk_i, .rst_ni, .d_i(can_issue), .q_o(rel_now)
   );

   // Completion event, LAT cycles after issue, carrying slot and tag
   fus_delay_line #(.W(EW+1), .DEPTH(LAT)) u_cmp (
      .clk_i, .rst_ni, .d_i({can_issue, head}), .q_o(cmp_q)
   );

   assign mat_slot = cmp_q[EW-1:TAG_W];
   assign mat_tag  = cmp_q[TAG_W-1:0];

   always_comb begin
      case ({rel_now, can_issue})
         2'b10:   free_d = free_q + 1'b1;
         2'b01:   free_d = free_q - 1'b1;
         default: free_d = free_q;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) free_q <= CW'(UNITS);
      else         free_q <= free_d;
   end

   assign issue_o      = can_issue;
   assign waiter_rel_o = head_stale;
   assign unit_free_o  = rel_now;
   assign cmp_vld_o    = cmp_q[EW] && (live_tag_i[mat_slot*TAG_W +: TAG_W] == mat_tag);
   assign cmp_slot_o   = mat_slot;
endmodule

// File: rtl/fus_issue_sched.sv
module fus_issue_sched #(
   parameter int          NUM_CLASS  = 3,
   parameter int          ADDR_CLASS = 2,
   parameter int          SLOT_W     = 3,
   parameter int          TAG_W      = 4,
   parameter int          QDEPTH     = 4,
   parameter logic [63:0] REPEAT_VEC = 64'h131,
   parameter logic [63:0] LAT_VEC    = 64'h253,
   parameter logic [63:0] UNITS_VEC  = 64'h112
) (
   input  logic                            clk_i,
   input  logic                            rst_ni,
   input  logic [NUM_CLASS-1:0]            push_vld_i,
   input  logic [NUM_CLASS*SLOT_W-1:0]     push_slot_i,
   input  logic [NUM_CLASS*TAG_W-1:0]      push_tag_i,
   input  logic [(1<<SLOT_W)*TAG_W-1:0]    live_tag_i,
   output logic [NUM_CLASS-1:0]            issue_o,
   output logic [NUM_CLASS-1:0]            waiter_rel_o,
   output logic [NUM_CLASS-1:0]            unit_free_o,
   output logic [NUM_CLASS-1:0]            done_vld_o,
   output logic [NUM_CLASS*SLOT_W-1:0]     done_slot_o,
   output logic                            addr_done_vld_o,
   output logic [SLOT_W-1:0]               addr_done_slot_o
);
   if (NUM_CLASS < 1 || NUM_CLASS > 16) begin : g_bad_nc
      $error("fus_issue_sched: NUM_CLASS must be 1..16");
   end
   if (ADDR_CLASS < 0 || ADDR_CLASS >= NUM_CLASS) begin : g_bad_ac
      $error("fus_issue_sched: ADDR_CLASS out of range");
   end

   for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
      localparam int REP   = fus_pkg::cfg_field(REPEAT_VEC, c);
      localparam int LAT   = fus_pkg::cfg_field(LAT_VEC, c);
      localparam int UNITS = fus_pkg::cfg_field(UNITS_VEC, c);

      if (REP < 1 || LAT < 1 || UNITS < 1) begin : g_bad_cfg
         $error("fus_issue_sched: interval, latency and units must be nonzero");
      end

      logic              cmp_vld;
      logic [SLOT_W-1:0] cmp_slot;

      fus_class_lane #(
         .SLOT_W(SLOT_W), .TAG_W(TAG_W), .QDEPTH(QDEPTH),
         .UNITS(UNITS), .REP(REP), .LAT(LAT)
      ) u_lane (
         .clk_i, .rst_ni,
         .push_vld_i  (push_vld_i[c]),
         .push_ent_i  ({push_slot_i[c*SLOT_W +: SLOT_W], push_tag_i[c*TAG_W +: TAG_W]}),
         .live_tag_i  (live_tag_i),
         .issue_o     (issue_o[c]),
         .waiter_rel_o(waiter_rel_o[c]),
         .unit_free_o (unit_free_o[c]),
         .cmp_vld_o   (cmp_vld),
         .cmp_slot_o  (cmp_slot)
      );

      if (c == ADDR_CLASS) begin : g_addr
         assign addr_done_vld_o                 = cmp_vld;
         assign addr_done_slot_o                = cmp_slot;
         assign done_vld_o[c]                   = 1'b0;
         assign done_slot_o[c*SLOT_W +: SLOT_W] = '0;
      end else begin : g_exec
         assign done_vld_o[c]                   = cmp_vld;
         assign done_slot_o[c*SLOT_W +: SLOT_W] = cmp_slot;
      end
   end
endmodule

// File: rtl/fus_issue_sched_chk.sv
module fus_issue_sched_chk #(
   parameter int          NUM_CLASS  = 3,
   parameter int          ADDR_CLASS = 2,
   parameter logic [63:0] REPEAT_VEC = 64'h131,
   parameter logic [63:0] LAT_VEC    = 64'h253,
   parameter logic [63:0] UNITS_VEC  = 64'h112
) (
   input logic                 clk_i,
   input logic                 rst_ni,
   input logic [NUM_CLASS-1:0] issue_o,
   input logic [NUM_CLASS-1:0] waiter_rel_o,
   input logic [NUM_CLASS-1:0] unit_free_o,
   input logic [NUM_CLASS-1:0] done_vld_o,
   input logic                 addr_done_vld_o
);
   for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
      localparam int REP   = fus_pkg::cfg_field(REPEAT_VEC, c);
      localparam int LAT   = fus_pkg::cfg_field(LAT_VEC, c);
      localparam int UNITS = fus_pkg::cfg_field(UNITS_VEC, c);

      int busy_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) busy_q <= 0;
         else         busy_q <= busy_q + int'(issue_o[c]) - int'(unit_free_o[c]);
      end

      // R4: busy units never exceed the configured count
      a_r4_busy_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
         busy_q <= UNITS);

      // R4: every unit release follows an issue by the repeat interval
      a_r4_free_after_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
         unit_free_o[c] |-> $past(issue_o[c], REP));

      // R8: a dropped stale head never issues in the same cycle
      a_r8_stale_no_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
         waiter_rel_o[c] |-> !issue_o[c]);

      if (c == ADDR_CLASS) begin : g_addr
         // R7: address completions trail their issue by the latency
         a_r7_addr_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
            addr_done_vld_o |-> $past(issue_o[c], LAT));
      end else begin : g_exec
         // R5: completions trail their issue by the latency
         a_r5_done_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
            done_vld_o[c] |-> $past(issue_o[c], LAT));
      end
   end
endmodule

bind fus_issue_sched fus_issue_sched_chk #(
   .NUM_CLASS(NUM_CLASS), .ADDR_CLASS(ADDR_CLASS),
   .REPEAT_VEC(REPEAT_VEC), .LAT_VEC(LAT_VEC), .UNITS_VEC(UNITS_VEC)
) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .issue_o(issue_o), .waiter_rel_o(waiter_rel_o),
   .unit_free_o(unit_free_o), .done_vld_o(done_vld_o), .addr_done_vld_o(addr_done_vld_o)
);

// File: tb/fus_issue_sched_tb_top.sv
module fus_issue_sched_tb_top;
   localparam int NC = 3;
   localparam int AC = 2;
   localparam int SW = 3;
   localparam int TW = 4;
   localparam int QD = 4;
   localparam int NS = 8;
   localparam int LATS [NC] = '{3, 5, 2};
   localparam int REPS [NC] = '{1, 3, 1};
   localparam int UNTS [NC] = '{2, 1, 1};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [NC-1:0]    push_vld = '0;
   logic [NC*SW-1:0] push_slot = '0;
   logic [NC*TW-1:0] push_tag = '0;
   logic [NS*TW-1:0] live_vec = '0;
   logic [NC-1:0]    issue_o, waiter_rel_o, unit_free_o, done_vld_o;
   logic [NC*SW-1:0] done_slot_o;
   logic             addr_done_vld_o;
   logic [SW-1:0]    addr_done_slot_o;

   fus_issue_sched #(
      .NUM_CLASS(NC), .ADDR_CLASS(AC), .SLOT_W(SW), .TAG_W(TW), .QDEPTH(QD),
      .REPEAT_VEC(64'h131), .LAT_VEC(64'h253), .UNITS_VEC(64'h112)
   ) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .push_vld_i(push_vld), .push_slot_i(push_slot),
      .push_tag_i(push_tag), .live_tag_i(live_vec), .issue_o(issue_o),
      .waiter_rel_o(waiter_rel_o), .unit_free_o(unit_free_o), .done_vld_o(done_vld_o),
      .done_slot_o(done_slot_o), .addr_done_vld_o(addr_done_vld_o),
      .addr_done_slot_o(addr_done_slot_o)
   );

   int tests = 0;
   int fails = 0;

   // stimulus for the next cycle
   bit pv [NC];
   int ps [NC];
   int pt [NC];
   int live [NS];

   // reference model
   int q_slot [NC][QD];
   int q_tag  [NC][QD];
   int q_cnt  [NC];
   int free_m [NC];
   bit d_v [NC][32];
   int d_s [NC][32];
   int d_t [NC][32];
   bit r_v [NC][32];
   int cyc = 0;

   // observation counters for directed runs
   int iss1_n, last_iss1, gap_bad, done1_n, done1_s7, wait0_n, iss0_n, addr_n, done2_n;

   task automatic chk(bit ok, string req, string what, int act, int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   task automatic clear_obs();
      iss1_n = 0; last_iss1 = -1; gap_bad = 0; done1_n = 0; done1_s7 = 0;
      wait0_n = 0; iss0_n = 0; addr_n = 0; done2_n = 0;
   endtask

   task automatic push(int c, int slot, int tag);
      pv[c] = 1'b1; ps[c] = slot; pt[c] = tag;
   endtask

   task automatic step();
      int idx, n_done;
      bit cyc_ok;
      @(negedge clk);
      for (int c = 0; c < NC; c++) begin
         push_vld[c] = pv[c];
         push_slot[c*SW +: SW] = SW'(ps[c]);
         push_tag[c*TW +: TW]  = TW'(pt[c]);
      end
      for (int s = 0; s < NS; s++) live_vec[s*TW +: TW] = TW'(live[s]);
      #2;
      idx = cyc % 32;
      n_done = 0;
      cyc_ok = 1'b1;
      for (int c = 0; c < NC; c++) begin
         bit rel, hv, stale, iss, mv, mok, e_done;
         rel   = r_v[c][idx];
         hv    = q_cnt[c] > 0;
         stale = hv && (live[q_slot[c][0]] != q_tag[c][0]);
         iss   = hv && !stale && (free_m[c] > 0 || rel);
         mv    = d_v[c][idx];
         mok   = mv && (live[d_s[c][idx]] == d_t[c][idx]);
         e_done = mok;
         if (e_done) n_done++;

         chk(issue_o[c] == iss, "R3", $sformatf("issue class %0d", c), int'(issue_o[c]), int'(iss));
         chk(unit_free_o[c] == rel, "R4", $sformatf("unit_free class %0d", c), int'(unit_free_o[c]), int'(rel));
         chk(waiter_rel_o[c] == stale, "R8", $sformatf("waiter class %0d", c), int'(waiter_rel_o[c]), int'(stale));
         if (c == AC) begin
            chk(done_vld_o[c] == 1'b0, "R7", "done on addr class", int'(done_vld_o[c]), 0);
            chk(addr_done_vld_o == e_done, (mv && !mok) ? "R6" : "R7", "addr_done_vld",
                int'(addr_done_vld_o), int'(e_done));
            if (e_done)
               chk(int'(addr_done_slot_o) == d_s[c][idx], "R7", "addr_done_slot",
                   int'(addr_done_slot_o), d_s[c][idx]);
            if (addr_done_vld_o != e_done) cyc_ok = 1'b0;
         end else begin
            chk(done_vld_o[c] == e_done, (mv && !mok) ? "R6" : "R5",
                $sformatf("done_vld class %0d", c), int'(done_vld_o[c]), int'(e_done));
            if (e_done)
               chk(int'(done_slot_o[c*SW +: SW]) == d_s[c][idx], "R5",
                   $sformatf("done_slot class %0d", c), int'(done_slot_o[c*SW +: SW]), d_s[c][idx]);
            if (done_vld_o[c] != e_done) cyc_ok = 1'b0;
         end

         // observation for directed runs
         if (c == 1 && issue_o[1]) begin
            if (last_iss1 >= 0 && cyc - last_iss1 != REPS[1]) gap_bad++;
            last_iss1 = cyc; iss1_n++;
         end
         if (c == 1 && done_vld_o[1]) begin
            done1_n++;
            if (done_slot_o[SW +: SW] == 3'd7) done1_s7++;
         end
         if (c == 0 && waiter_rel_o[0]) wait0_n++;
         if (c == 0 && issue_o[0]) iss0_n++;

         // advance model state
         free_m[c] = free_m[c] + int'(rel) - int'(iss);
         d_v[c][idx] = 1'b0;
         r_v[c][idx] = 1'b0;
         if (iss) begin
            d_v[c][(cyc + LATS[c]) % 32] = 1'b1;
            d_s[c][(cyc + LATS[c]) % 32] = q_slot[c][0];
            d_t[c][(cyc + LATS[c]) % 32] = q_tag[c][0];
            r_v[c][(cyc + REPS[c]) % 32] = 1'b1;
         end
         begin
            int pre;
            pre = q_cnt[c];
            if (iss || stale) begin
               for (int k = 0; k < QD - 1; k++) begin
                  q_slot[c][k] = q_slot[c][k+1];
                  q_tag[c][k]  = q_tag[c][k+1];
               end
               q_cnt[c]--;
            end
            if (pv[c] && pre < QD) begin
               q_slot[c][q_cnt[c]] = ps[c];
               q_tag[c][q_cnt[c]]  = pt[c];
               q_cnt[c]++;
            end
         end
         pv[c] = 1'b0;
      end
      if (addr_done_vld_o) addr_n++;
      if (done_vld_o[AC]) done2_n++;
      if (n_done > 1) chk(cyc_ok, "R9", "simultaneous completions", int'(cyc_ok), 1);
      cyc++;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      for (int c = 0; c < NC; c++) begin
         pv[c] = 1'b0; ps[c] = 0; pt[c] = 0;
         q_cnt[c] = 0; free_m[c] = UNTS[c];
         for (int k = 0; k < 32; k++) begin
            d_v[c][k] = 1'b0; r_v[c][k] = 1'b0; d_s[c][k] = 0; d_t[c][k] = 0;
         end
      end
      for (int s = 0; s < NS; s++) live[s] = s;
      for (int s = 0; s < NS; s++) live_vec[s*TW +: TW] = TW'(live[s]);
      clear_obs();

      // R1: outputs quiet during reset
      repeat (3) @(negedge clk);
      chk(issue_o == '0 && waiter_rel_o == '0 && unit_free_o == '0, "R1", "issue/waiter/free in reset",
          int'({issue_o, waiter_rel_o, unit_free_o}), 0);
      chk(done_vld_o == '0 && addr_done_vld_o == 1'b0, "R1", "done in reset",
          int'({done_vld_o, addr_done_vld_o}), 0);
      rst_n = 1'b1;
      step();
      chk(issue_o == '0 && done_vld_o == '0, "R1", "first cycle after reset",
          int'({issue_o, done_vld_o}), 0);

      // R2/R4: seven pushes into the single-unit class, the last one overflows
      clear_obs();
      for (int i = 1; i <= 7; i++) begin
         push(1, i, live[i]);
         step();
      end
      repeat (25) step();
      chk(iss1_n == 6, "R2", "issues after overflow", iss1_n, 6);
      chk(done1_n == 6, "R2", "completions after overflow", done1_n, 6);
      chk(done1_s7 == 0, "R2", "ignored push completed", done1_s7, 0);
      chk(gap_bad == 0, "R4", "back-to-back issue spacing", gap_bad, 0);

      // R8: head stale on arrival
      clear_obs();
      push(0, 0, (live[0] + 1) % 16);
      repeat (6) step();
      chk(wait0_n == 1, "R8", "waiter releases", wait0_n, 1);
      chk(iss0_n == 0, "R8", "issues of stale head", iss0_n, 0);

      // R6: flush while in flight
      clear_obs();
      push(1, 5, live[5]);
      step();
      step();
      live[5] = (live[5] + 1) % 16;
      repeat (8) step();
      chk(iss1_n == 1, "R6", "in-flight issue", iss1_n, 1);
      chk(done1_n == 0, "R6", "flushed completion", done1_n, 0);

      // R7: address class routes to its own port
      clear_obs();
      push(AC, 3, live[3]);
      repeat (5) step();
      chk(addr_n == 1, "R7", "address completions", addr_n, 1);
      chk(done2_n == 0, "R7", "done pulses of addr class", done2_n, 0);

      // R9 and mixed traffic: random pushes and flushes
      for (int n = 0; n < 4000; n++) begin
         for (int c = 0; c < NC; c++) begin
            if ($urandom_range(99) < 40) begin
               int s;
               s = $urandom_range(NS - 1);
               push(c, s, ($urandom_range(99) < 90) ? live[s] : (live[s] + 3) % 16);
            end
         end
         if ($urandom_range(99) < 5) begin
            int s;
            s = $urandom_range(NS - 1);
            live[s] = (live[s] + 1) % 16;
         end
         step();
      end
      repeat (20) step();

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule